// File: doc/BRIEF.md
# Polarity-Configurable PWM Timer

This block is a single-channel pulse-width modulation timer behind a small synchronous register port. A counter runs on a prescaled tick and wraps at a programmed period. The output pin sits at a programmable "active" level while the counter is below a programmed compare value, and at the opposite level for the rest of the cycle. The waveform is therefore left-aligned.

While the timer is stopped, the pin is held at a separately programmed idle level. Software can write the counter directly. The usual sequence is to program period and compare, set the control word, and then write zero to the counter. The new waveform then starts cleanly at the beginning of a cycle.

The bus has an address, a write strobe, write data and a registered read data return. There is no read strobe: the read data always reflects the address presented on the previous clock.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is low.
- R2: Registers are decoded on `bus_addr[3:2]`: 0x0 is the counter, 0x4 the period, 0x8 the compare (duty) value, and 0xC the control word. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` shows the register addressed at the previous edge, and period and duty read back all 32 bits.
- R3: The counter advances by one per prescale tick only while control bit 0 (run) and control bit 1 (repeat) are both 1. After reaching period−1 it wraps to 0. With period 0, the counter goes to 0 on its next tick and stays there.
- R4: While running, the output is registered one clock after the counter value it reflects. It equals control bit 3 (1 = high) when counter < duty, and the inverse of bit 3 otherwise.
- R5: A duty of 0 gives the inverse of bit 3 for the whole cycle. A duty ≥ period gives the bit 3 level for the whole cycle. A period of 0 gives the inverse of bit 3.
- R6: When control bit 0 is 0, the counter holds its value and the output equals control bit 4 from the next clock onward. When bit 0 is 1 and bit 1 is 0, the counter also holds, and the output keeps comparing the held value.
- R7: A write to offset 0x0 loads the counter with the write data. This takes priority over advancing and restarts the prescaler. A loaded value at or above period−1 wraps to 0 on the next tick.
- R8: Control bits 2 and 5–31 are ignored on write and read as 0. A counter read returns the live counter value.
- R9: Parameter `PRESCALE` (1 or 2) sets the tick rate. After a counter write, the counter advances once every `PRESCALE` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | PWM output pin |

## Verification
The properties assume that the bus uses word-aligned addresses only, since they recognise a counter write by the full address 0x0 and a control read by 0xC. They also assume that a written counter value is taken in the cycle after the strobe. The stimulus only drives aligned offsets. It changes the bus only on falling clock edges and holds the strobe for exactly one rising edge. The stimulus runs the default and the divide-by-two variants side by side on one bus. In each sweep it restarts the counter with a zero write before measuring, so every expected level follows arithmetically from the restart edge.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Control word bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_REPEAT  = 1;
    localparam int CB_DUTYPOL = 3;
    localparam int CB_IDLEPOL = 4;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic idle_high;
        logic duty_high;
        logic repeat_on;
        logic run_on;
    } ctrl_t;

    typedef struct packed {
        logic              cnt_load;
        logic [DATA_W-1:0] load_val;
    } load_req_t;

    function automatic reg_sel_e decode_sel(input logic [1:0] word_idx);
        return reg_sel_e'(word_idx);
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run_on    = w[CB_RUN];
        c.repeat_on = w[CB_REPEAT];
        c.duty_high = w[CB_DUTYPOL];
        c.idle_high = w[CB_IDLEPOL];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[CB_RUN]     = c.run_on;
        w[CB_REPEAT]  = c.repeat_on;
        w[CB_DUTYPOL] = c.duty_high;
        w[CB_IDLEPOL] = c.idle_high;
        return w;
    endfunction

endpackage

// File: rtl/pwm_bus_regs.sv
module pwm_bus_regs
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] period_q,
    output logic [DATA_W-1:0] duty_q,
    output ctrl_t             ctrl_q,
    output load_req_t         load_req
);

    reg_sel_e sel;
    logic     unused_lsb;

    assign sel        = decode_sel(bus_addr[3:2]);
    assign unused_lsb = ^bus_addr[1:0];

    // Counter load request goes straight to the counter unit
    always_comb begin
        load_req.cnt_load = bus_wr && (sel == SEL_COUNT);
        load_req.load_val = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            duty_q   <= '0;
            ctrl_q   <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_PERIOD: period_q <= bus_wdata;
                SEL_DUTY:   duty_q   <= bus_wdata;
                SEL_CTRL:   ctrl_q   <= unpack_ctrl(bus_wdata);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            case (sel)
                SEL_COUNT:  bus_rdata <= cnt_val;
                SEL_PERIOD: bus_rdata <= period_q;
                SEL_DUTY:   bus_rdata <= duty_q;
                SEL_CTRL:   bus_rdata <= pack_ctrl(ctrl_q);
                default:    bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRESCALE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE <= 1) begin : g_direct
            logic unused_in;
            assign unused_in = ^{clk, rst, restart};
            assign tick      = run;
        end else begin : g_div
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    pre_q <= '0;
                end else if (run) begin
                    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                end
            end

            assign tick = run && (pre_q == PRE_LAST);
        end
    endgenerate

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] period,
    input  load_req_t         load_req,
    output logic [DATA_W-1:0] cnt_q
);

    logic wrap;

    assign wrap = (period == '0) || (cnt_q >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_req.cnt_load) begin
            cnt_q <= load_req.load_val;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] period,
    input  logic [DATA_W-1:0] duty,
    output logic              pwm_out
);

    logic in_duty;

    assign in_duty = (period != '0) && (cnt < duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= 1'b0;
        end else if (!ctrl.run_on) begin
            pwm_out <= ctrl.idle_high;
        end else begin
            pwm_out <= in_duty ? ctrl.duty_high : !ctrl.duty_high;
        end
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int PRESCALE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    ctrl_t             ctrl_s;
    load_req_t         load_s;
    logic [DATA_W-1:0] period_s;
    logic [DATA_W-1:0] duty_s;
    logic [DATA_W-1:0] cnt_s;
    logic              tick_s;
    logic              run_s;

    assign run_s = ctrl_s.run_on && ctrl_s.repeat_on;

    pwm_bus_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_s),
        .bus_rdata (bus_rdata),
        .period_q  (period_s),
        .duty_q    (duty_s),
        .ctrl_q    (ctrl_s),
        .load_req  (load_s)
    );

    pwm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run_s),
        .restart (load_s.cnt_load),
        .tick    (tick_s)
    );

    pwm_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_s),
        .period   (period_s),
        .load_req (load_s),
        .cnt_q    (cnt_s)
    );

    pwm_wave_out u_wave (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl_s),
        .cnt     (cnt_s),
        .period  (period_s),
        .duty    (duty_s),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker
    import pwm_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pwm_out,
    input ctrl_t             ctrl_s,
    input logic [DATA_W-1:0] cnt_s,
    input logic [DATA_W-1:0] period_s,
    input logic [DATA_W-1:0] duty_s
);

    a_r3_stays_below_period: assert property (@(posedge clk) disable iff (rst)
        (ctrl_s.run_on && ctrl_s.repeat_on && period_s != '0 && cnt_s < period_s
         && !(bus_wr && bus_addr == 4'h0))
        |=> (cnt_s < $past(period_s)));

    a_r4_duty_level: assert property (@(posedge clk) disable iff (rst)
        (ctrl_s.run_on && period_s != '0 && cnt_s < duty_s)
        |=> (pwm_out == $past(ctrl_s.duty_high)));

    a_r5_flat_inactive: assert property (@(posedge clk) disable iff (rst)
        (ctrl_s.run_on && (duty_s == '0 || period_s == '0))
        |=> (pwm_out == !$past(ctrl_s.duty_high)));

    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_s.run_on) |=> (pwm_out == $past(ctrl_s.idle_high)));

    a_r6_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_s.run_on && ctrl_s.repeat_on) && !(bus_wr && bus_addr == 4'h0))
        |=> $stable(cnt_s));

    a_r7_count_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'h0) |=> (cnt_s == $past(bus_wdata)));

    a_r8_ctrl_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'hC) |=> (bus_rdata[31:5] == '0 && bus_rdata[2] == 1'b0));

endmodule

bind pwm_timer pwm_timer_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ctrl_s    (ctrl_s),
    .cnt_s     (cnt_s),
    .period_s  (period_s),
    .duty_s    (duty_s)
);

// File: tb/test_pwm_timer.sv
`timescale 1ns/1ps
module test_pwm_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = 4'h0;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rd1, rd2;
    logic        out1, out2;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_timer #(.PRESCALE(1)) i_pwm_timer (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rd1), .pwm_out(out1)
    );

    pwm_timer #(.PRESCALE(2)) i_pwm_timer_p2 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rd2), .pwm_out(out2)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] r1, output logic [31:0] r2);
        @(negedge clk);
        addr = a; wr = 1'b0;
        @(negedge clk);
        r1 = rd1; r2 = rd2;
    endtask

    // Expected level k edges after the restart edge, for prescale s
    function automatic logic exp_level(int p, int d, int s, int k, logic dp);
        int c;
        if (p == 0) return !dp;
        c = ((k - 1) / s) % p;
        return (c < d) ? dp : !dp;
    endfunction

    logic [31:0] a1, a2, b1, b2;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 out", {31'b0, out1}, 32'h0);
        check("R1 out p2", {31'b0, out2}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            bus_read(4'(i * 4), a1, a2);
            check("R1 reg", a1, 32'h0);
            check("R1 reg p2", a2, 32'h0);
        end

        // R2: register readback
        bus_write(4'h4, 32'hDEADBEEF);
        bus_read(4'h4, a1, a2);
        check("R2 period", a1, 32'hDEADBEEF);
        bus_write(4'h8, 32'h12345678);
        bus_read(4'h8, a1, a2);
        check("R2 duty", a2, 32'h12345678);

        // R8: spare control bits read as zero
        bus_write(4'hC, 32'hFFFFFFFF);
        bus_read(4'hC, a1, a2);
        check("R8 ctrl all ones", a1, 32'h0000001B);
        bus_write(4'hC, 32'h00000024);
        bus_read(4'hC, a1, a2);
        check("R8 spare only", a1, 32'h0);
        check("R8 out idle", {31'b0, out1}, 32'h0);

        // R4/R5/R9: sweep of period, duty and polarity
        for (int p = 0; p < 6; p++) begin
            for (int d = 0; d < 7; d++) begin
                for (int dp = 0; dp < 2; dp++) begin
                    logic ip;
                    string tag;
                    int n;
                    ip = d[0];
                    tag = (p != 0 && d > 0 && d < p) ? "R4 wave" : "R5 flat";
                    n = 4 * ((p == 0) ? 1 : p) + 2;
                    bus_write(4'hC, {27'b0, ip, 4'b0});
                    bus_write(4'h4, 32'(p));
                    bus_write(4'h8, 32'(d));
                    bus_write(4'hC, {27'b0, ip, dp[0], 3'b011});
                    bus_write(4'h0, 32'h0);
                    for (int k = 1; k <= n; k++) begin
                        @(negedge clk);
                        check(tag, {31'b0, out1}, {31'b0, exp_level(p, d, 1, k, dp[0])});
                        check("R9 wave p2", {31'b0, out2}, {31'b0, exp_level(p, d, 2, k, dp[0])});
                    end
                end
            end
        end

        // R3/R9: live counter reads with wrap
        bus_write(4'hC, 32'h0);
        bus_write(4'h4, 32'd4);
        bus_write(4'h8, 32'd2);
        bus_write(4'hC, 32'h0B);
        bus_write(4'h0, 32'h0);
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            check("R3 count wrap", rd1, 32'((j - 1) % 4));
            check("R9 count p2", rd2, 32'(((j - 1) / 2) % 4));
        end

        // R3: period zero parks counter at zero
        bus_write(4'h4, 32'd0);
        bus_write(4'h0, 32'd3);
        @(negedge clk); @(negedge clk);
        for (int j = 3; j <= 8; j++) begin
            @(negedge clk);
            check("R3 period zero", rd1, 32'h0);
            check("R3 period zero p2", rd2, 32'h0);
        end

        // R7: load while running
        bus_write(4'h4, 32'd10);
        bus_write(4'h0, 32'd7);
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            check("R7 load run", rd1, 32'(7 + (j - 1)));
            check("R7 load run p2", rd2, 32'(7 + (j - 1) / 2));
        end
        bus_write(4'h0, 32'd20);
        @(negedge clk);
        check("R7 beyond period", rd1, 32'd20);
        check("R7 beyond period p2", rd2, 32'd20);
        @(negedge clk);
        check("R7 wrap after load", rd1, 32'h0);
        @(negedge clk);
        check("R7 wrap after load p2", rd2, 32'h0);

        // R6: disable with idle high, counter frozen
        bus_write(4'h4, 32'd5);
        bus_write(4'h8, 32'd2);
        bus_write(4'hC, 32'h0B);
        bus_write(4'h0, 32'h0);
        repeat (3) @(negedge clk);
        bus_write(4'hC, 32'h18);
        addr = 4'h0;
        @(negedge clk);
        check("R6 idle high", {31'b0, out1}, 32'h1);
        check("R6 idle high p2", {31'b0, out2}, 32'h1);
        a1 = rd1; a2 = rd2;
        repeat (5) @(negedge clk);
        b1 = rd1; b2 = rd2;
        check("R6 frozen", b1, a1);
        check("R6 frozen p2", b2, a2);
        check("R6 still idle", {31'b0, out1}, 32'h1);
        bus_write(4'hC, 32'h08);
        @(negedge clk);
        check("R6 idle low", {31'b0, out1}, 32'h0);
        check("R6 idle low p2", {31'b0, out2}, 32'h0);

        // R6: run without repeat holds counter, output compares held value
        bus_write(4'h8, 32'd4);
        bus_write(4'hC, 32'h09);
        bus_write(4'h0, 32'd3);
        repeat (6) @(negedge clk);
        bus_read(4'h0, a1, a2);
        check("R6 no repeat hold", a1, 32'd3);
        check("R6 no repeat hold p2", a2, 32'd3);
        check("R6 held compare", {31'b0, out1}, 32'h1);
        bus_write(4'h8, 32'd2);
        @(negedge clk);
        check("R6 held compare low", {31'b0, out2}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule